// File: doc/BRIEF.md
# Synchronous Bus Master Cycle Generator

This block sits between a simple CPU-side request port and a synchronous parallel bus with a 32-bit data path. When it is idle, it accepts one request: read or write, an address, a transfer size (byte, half-word or word) and, for writes, the data. It then runs one complete bus cycle. The bus cycle has three active-low strobes: a cycle enable, a write strobe and a read strobe. It also drives four active-low byte-lane selects. Every strobe asserts on a falling clock edge and releases on a rising clock edge. When no extension is configured, the bus data moves on the fourth rising edge after the enable strobe goes low.

A cycle can be made longer in two ways. The first is a count of extra wait clocks, latched with the request. The second is a handshake mode: the cycle is held past its base length until the slave raises a ready input. Sub-word transfers use the lanes that the low address bits select. Write data is moved up onto those lanes. Read data is moved down to bit 0 and zero-extended. At the sampling edge, the result is registered into the CPU-side read register and a one-clock completion pulse is given. The shared data wires appear as a separate input, output and output-enable.

Top module: `bus_cycle_master`

## Requirements
- R1: While reset is held and afterwards until a request is accepted, all three strobes and all four lane selects are high (inactive), the data output-enable is low, and the busy and done flags are low.
- R2: A request is accepted on a rising edge where req_valid is high and busy is low. busy is high from that edge on. The cycle-enable strobe goes low on the falling edge half a clock later, not before.
- R3: For a read, the read strobe goes low together with the enable strobe and the write strobe stays high. For a write, the write strobe goes low and the read strobe stays high. The two strobes are never low at the same time. Both rise on the edge where the enable strobe rises.
- R4: With handshake mode off and W configured wait clocks, the enable strobe rises on rising edge number 4+W after its fall. Edges are counted from the first rising edge after the fall. This is also the edge where read data is captured. The ready input has no effect in this mode.
- R5: Lane-select bit i (active low) stands for data bits 8i+7..8i. A byte transfer selects lane addr[1:0]. A half-word transfer selects lanes 2*addr[1] and 2*addr[1]+1, ignoring addr[0]. A word transfer (size code 2 or 3) selects all four lanes. Size codes: 0 byte, 1 half-word, 2 word. Lanes are driven during the whole busy period.
- R6: For a write, the data output-enable is high for the whole busy period. The data output carries the byte at bits 8*L+7..8*L, where L is the byte lane from R5. It carries the half-word at bits 16*addr[1]+15..16*addr[1]. Unselected lanes are zero. For a read, the output-enable stays low.
- R7: For a read, the selected bus lanes are captured at the completion edge and placed at bit 0 of rd_data, zero-extended. done is high for exactly the one clock that follows that edge.
- R8: With handshake mode on, the cycle completes on the first rising edge that is at or after edge 4 and where ready is high. The configured wait count is ignored.
- R9: busy falls on the completion edge. A request held high while busy does not start a cycle and does not change the bus address.
- R10: The address and lane selects do not change while the enable strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 1 half-word, 2 or 3 word |
| req_addr | input | ADDR_W | Byte address of the transfer |
| req_wdata | input | 32 | Write data, right-aligned |
| cfg_wait | input | WAIT_W | Extra wait clocks, latched at acceptance |
| cfg_use_ready | input | 1 | 1 selects the ready handshake, latched at acceptance |
| busy | output | 1 | A bus cycle is in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 32 | Last read result, right-aligned, zero-extended |
| bus_addr | output | ADDR_W | Bus address |
| bus_ne_n | output | 1 | Cycle enable strobe, active low |
| bus_nwe_n | output | 1 | Write strobe, active low |
| bus_noe_n | output | 1 | Read strobe, active low |
| bus_nbl_n | output | 4 | Byte-lane selects, active low |
| bus_dout | output | 32 | Data driven toward the bus |
| bus_doe | output | 1 | Output-enable for bus_dout |
| bus_din | input | 32 | Data received from the bus |
| bus_ready | input | 1 | Slave ready, used in handshake mode |

## Verification
The checker watches several rules on every clock. The two data strobes are never low together. Nothing strobes while the block is idle. The enable strobe is never low unless the block is busy. The address and lane selects hold while the enable strobe is low. done lasts one clock and never overlaps busy. The output-enable appears only during writes. Other behaviour can only be shown by the bench's sweeps. These cover the exact edge where the cycle ends for each wait count and each ready timing, the lane pattern and data placement for every size and offset, the zero-extended read result, and the fact that a request held high during a cycle is dropped.

// File: rtl/bm_pkg.sv
package bm_pkg;

    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int LANE_IW = $clog2(LANES);
    localparam int BASE_EDGES = 4;

    typedef enum logic [1:0] {
        SZ_BYTE     = 2'd0,
        SZ_HALF     = 2'd1,
        SZ_WORD     = 2'd2,
        SZ_WORD_ALT = 2'd3
    } xfer_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } bus_state_e;

    // Lane plan for one transfer: which lanes are live, the lowest one,
    // and the right-aligned keep mask for the payload.
    typedef struct packed {
        logic [LANES-1:0]   mask;
        logic [LANE_IW-1:0] base;
        logic [DATA_W-1:0]  keep;
    } lane_plan_t;

    // Latched request carried through the cycle.
    typedef struct packed {
        logic              write;
        xfer_size_e        size;
        logic [DATA_W-1:0] wdata;
    } req_info_t;

    function automatic lane_plan_t plan_lanes(input xfer_size_e sz,
                                              input logic [LANE_IW-1:0] off);
        lane_plan_t p;
        case (sz)
            SZ_BYTE: begin
                p.base = off;
                p.mask = LANES'(1) << off;
                p.keep = DATA_W'(8'hFF);
            end
            SZ_HALF: begin
                p.base = {off[LANE_IW-1], {(LANE_IW-1){1'b0}}};
                p.mask = LANES'(3) << p.base;
                p.keep = DATA_W'(16'hFFFF);
            end
            default: begin
                p.base = '0;
                p.mask = '1;
                p.keep = '1;
            end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/bm_lane_steer.sv
module bm_lane_steer
    import bm_pkg::*;
(
    input  xfer_size_e          size,
    input  logic [LANE_IW-1:0]  offset,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W-1:0]   bus_in,
    output logic [LANES-1:0]    lane_mask,
    output logic [DATA_W-1:0]   bus_out,
    output logic [DATA_W-1:0]   rd_aligned
);
    lane_plan_t plan;
    logic [DATA_W-1:0] kept_w;
    logic [DATA_W-1:0] lane_in;

    always_comb plan = plan_lanes(size, offset);
    assign lane_mask = plan.mask;
    assign kept_w    = wdata & plan.keep;

    // Each bus lane picks its byte from the payload relative to the base
    // lane; bus lanes outside the plan carry zero in both directions.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_IW-1:0] rel;
        assign rel = LANE_IW'(g) - plan.base;
        assign bus_out[8*g +: 8] = plan.mask[g] ? kept_w[8*rel +: 8] : 8'h00;
        assign lane_in[8*g +: 8] = plan.mask[g] ? bus_in[8*g +: 8] : 8'h00;
    end

    assign rd_aligned = lane_in >> {plan.base, 3'b000};

endmodule

// File: rtl/bm_wait_timer.sv
module bm_wait_timer
    import bm_pkg::*;
#(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              run,
    input  logic [WAIT_W-1:0] wait_cfg,
    input  logic              use_ready,
    input  logic              ready,
    output logic              fire
);
    localparam int CNT_W = WAIT_W + 2;
    localparam logic [CNT_W-1:0] LAST_BASE = CNT_W'(BASE_EDGES - 1);

    logic [CNT_W-1:0] edges_q;
    logic             base_done;
    logic             wait_done;

    // edges_q holds the number of rising edges already seen after the one
    // that accepted the request.
    always_ff @(posedge clk) begin
        if (rst || start) begin
            edges_q <= '0;
        end else if (run && edges_q != '1) begin
            edges_q <= edges_q + 1'b1;
        end
    end

    assign base_done = edges_q >= LAST_BASE;
    assign wait_done = edges_q == (LAST_BASE + CNT_W'(wait_cfg));
    assign fire = run && (use_ready ? (base_done && ready) : wait_done);

endmodule

// File: rtl/bm_strobe_phase.sv
module bm_strobe_phase (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic write,
    output logic ne_n,
    output logic nwe_n,
    output logic noe_n
);
    logic armed_q;

    // Falling-edge copy of the cycle flag: strobes start half a clock
    // after acceptance; dropping 'active' on a rising edge releases them.
    always_ff @(negedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= active;
        end
    end

    logic on;
    assign on    = active & armed_q;
    assign ne_n  = ~on;
    assign nwe_n = ~(on & write);
    assign noe_n = ~(on & ~write);

endmodule

// File: rtl/bus_cycle_master.sv
module bus_cycle_master
    import bm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              cfg_use_ready,
    output logic              busy,
    output logic              done,
    output logic [31:0]       rd_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_ne_n,
    output logic              bus_nwe_n,
    output logic              bus_noe_n,
    output logic [3:0]        bus_nbl_n,
    output logic [31:0]       bus_dout,
    output logic              bus_doe,
    input  logic [31:0]       bus_din,
    input  logic              bus_ready
);
    bus_state_e        state_q;
    req_info_t         req_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WAIT_W-1:0] wait_q;
    logic              rdy_mode_q;
    logic [DATA_W-1:0] rd_q;
    logic              done_q;

    logic              accept;
    logic              in_xfer;
    logic              fire;
    logic [LANES-1:0]  lane_mask;
    logic [DATA_W-1:0] steered;
    logic [DATA_W-1:0] aligned;

    assign in_xfer = state_q == ST_XFER;
    assign accept  = (state_q == ST_IDLE) && req_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            req_q      <= '0;
            addr_q     <= '0;
            wait_q     <= '0;
            rdy_mode_q <= 1'b0;
            rd_q       <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    state_q     <= ST_XFER;
                    req_q.write <= req_write;
                    req_q.size  <= xfer_size_e'(req_size);
                    req_q.wdata <= req_wdata;
                    addr_q      <= req_addr;
                    wait_q      <= cfg_wait;
                    rdy_mode_q  <= cfg_use_ready;
                end
                ST_XFER: if (fire) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                    if (!req_q.write) begin
                        rd_q <= aligned;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    bm_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .run       (in_xfer),
        .wait_cfg  (wait_q),
        .use_ready (rdy_mode_q),
        .ready     (bus_ready),
        .fire      (fire)
    );

    bm_lane_steer u_steer (
        .size       (req_q.size),
        .offset     (addr_q[LANE_IW-1:0]),
        .wdata      (req_q.wdata),
        .bus_in     (bus_din),
        .lane_mask  (lane_mask),
        .bus_out    (steered),
        .rd_aligned (aligned)
    );

    bm_strobe_phase u_strobe (
        .clk   (clk),
        .rst   (rst),
        .active(in_xfer),
        .write (req_q.write),
        .ne_n  (bus_ne_n),
        .nwe_n (bus_nwe_n),
        .noe_n (bus_noe_n)
    );

    assign busy      = in_xfer;
    assign done      = done_q;
    assign rd_data   = rd_q;
    assign bus_addr  = addr_q;
    assign bus_nbl_n = in_xfer ? ~lane_mask : '1;
    assign bus_doe   = in_xfer & req_q.write;
    assign bus_dout  = steered;

endmodule

// File: rtl/bm_checker.sv
module bm_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ne_n,
    input logic              bus_nwe_n,
    input logic              bus_noe_n,
    input logic [3:0]        bus_nbl_n,
    input logic              bus_doe
);
    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(!bus_nwe_n && !bus_noe_n));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (bus_ne_n && bus_nwe_n && bus_noe_n && bus_nbl_n == 4'hF && !bus_doe));

    assert_enable_needs_busy_R2: assert property (@(posedge clk) disable iff (rst)
        !bus_ne_n |-> busy);

    assert_addr_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (!bus_ne_n && $past(!bus_ne_n)) |-> ($stable(bus_addr) && $stable(bus_nbl_n)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    assert_doe_write_only_R6: assert property (@(posedge clk) disable iff (rst)
        bus_doe |-> (busy && bus_noe_n));
endmodule

bind bus_cycle_master bm_checker #(.ADDR_W(ADDR_W)) u_bm_checker (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .bus_addr  (bus_addr),
    .bus_ne_n  (bus_ne_n),
    .bus_nwe_n (bus_nwe_n),
    .bus_noe_n (bus_noe_n),
    .bus_nbl_n (bus_nbl_n),
    .bus_doe   (bus_doe)
);

// File: tb/tb_bus_cycle_master.sv
module tb_bus_cycle_master;
    localparam int AW = 16;
    localparam int WW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [1:0]    req_size = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [WW-1:0] cfg_wait = '0;
    logic          cfg_use_ready = 1'b0;
    logic          busy, done;
    logic [31:0]   rd_data;
    logic [AW-1:0] bus_addr;
    logic          bus_ne_n, bus_nwe_n, bus_noe_n;
    logic [3:0]    bus_nbl_n;
    logic [31:0]   bus_dout;
    logic          bus_doe;
    logic [31:0]   bus_din = '0;
    logic          bus_ready = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    bus_cycle_master #(.ADDR_W(AW), .WAIT_W(WW)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_wait(cfg_wait), .cfg_use_ready(cfg_use_ready), .busy(busy),
        .done(done), .rd_data(rd_data), .bus_addr(bus_addr),
        .bus_ne_n(bus_ne_n), .bus_nwe_n(bus_nwe_n), .bus_noe_n(bus_noe_n),
        .bus_nbl_n(bus_nbl_n), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_din(bus_din), .bus_ready(bus_ready)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic xfer(input bit wr, input int sz, input int off,
                        input logic [31:0] wd, input logic [31:0] din,
                        input int waits, input bit rmode, input int rdy_at);
        int base, exp_end, end_e;
        logic [3:0]    lanes;
        logic [31:0]   msk, exp_wd, exp_rd;
        logic [AW-1:0] a;
        base   = (sz == 0) ? off : (sz == 1) ? (off & 2) : 0;
        lanes  = (sz == 0) ? 4'(1 << off) : (sz == 1) ? 4'(3 << base) : 4'hF;
        msk    = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
        exp_wd = (wd & msk) << (8 * base);
        exp_rd = (din >> (8 * base)) & msk;
        a      = AW'(16'h5A00 | (sz << 4) | off);
        exp_end = rmode ? ((rdy_at > 4) ? rdy_at : 4) : 4 + waits;
        end_e  = 0;

        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = 2'(sz); req_addr = a;
        req_wdata = wd; cfg_wait = WW'(waits); cfg_use_ready = rmode;
        bus_din = din; bus_ready = rmode && (rdy_at <= 1);

        @(posedge clk); #2;
        req_addr = ~a;   // R9: held request while busy must be dropped
        chk(busy == 1'b1, "R9 busy after accept", 32'(busy), 1);
        chk(bus_ne_n == 1'b1, "R2 enable not before falling edge", 32'(bus_ne_n), 1);
        chk(bus_addr == a, "R10 address driven", 32'(bus_addr), 32'(a));
        chk(bus_nbl_n == ~lanes, "R5 lane selects", 32'(bus_nbl_n), 32'(~lanes));
        chk(bus_doe == wr, "R6 output-enable", 32'(bus_doe), 32'(wr));
        if (wr) chk(bus_dout == exp_wd, "R6 steered write data", bus_dout, exp_wd);

        @(negedge clk); #2;
        chk(bus_ne_n == 1'b0, "R2 enable low after falling edge", 32'(bus_ne_n), 0);
        chk(bus_nwe_n == !wr && bus_noe_n == wr, "R3 strobe select",
            {30'd0, bus_nwe_n, bus_noe_n}, {30'd0, !wr, wr});

        for (int e = 1; e <= 40; e++) begin
            @(posedge clk); #2;
            if (bus_ne_n) begin
                end_e = e;
                break;
            end
            if (bus_addr != a || bus_nbl_n != ~lanes)
                chk(1'b0, "R10 address or lanes moved", 32'(bus_addr), 32'(a));
            if (rmode && e == rdy_at - 1) bus_ready = 1'b1;
        end
        req_valid = 1'b0;
        chk(end_e == exp_end, rmode ? "R8 handshake end edge" : "R4 wait end edge",
            32'(end_e), 32'(exp_end));
        chk(done == 1'b1, "R7 done pulse", 32'(done), 1);
        chk(busy == 1'b0, "R9 busy released", 32'(busy), 0);
        chk(bus_nwe_n && bus_noe_n, "R3 strobes released",
            {30'd0, bus_nwe_n, bus_noe_n}, 32'd3);
        if (!wr) chk(rd_data == exp_rd, "R7 aligned read data", rd_data, exp_rd);

        @(posedge clk); #2;
        chk(done == 1'b0, "R7 done one clock", 32'(done), 0);
        chk(busy == 1'b0 && bus_ne_n == 1'b1 && bus_addr == a,
            "R9 held request ignored", 32'(bus_addr), 32'(a));
        bus_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk(bus_ne_n && bus_nwe_n && bus_noe_n && bus_nbl_n == 4'hF && !bus_doe
            && !busy && !done, "R1 reset state",
            {23'd0, bus_ne_n, bus_nwe_n, bus_noe_n, bus_nbl_n, bus_doe, busy, done},
            {23'd0, 3'b111, 4'hF, 3'b000});
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #2;
        chk(bus_ne_n && !busy && bus_nbl_n == 4'hF, "R1 idle after reset",
            {27'd0, bus_ne_n, bus_nbl_n}, {27'd0, 1'b1, 4'hF});

        for (int wr = 0; wr < 2; wr++)
            for (int sz = 0; sz < 3; sz++)
                for (int off = 0; off < 4; off++)
                    for (int w = 0; w < 4; w++)
                        xfer(wr[0], sz, off, 32'hC3A5_9617 + 32'(off * 7),
                             32'h8E71_D24B ^ 32'(w << 9), w, 1'b0, 0);

        // R8: handshake mode, configured wait count must not matter
        for (int wr = 0; wr < 2; wr++) begin
            xfer(wr[0], 2, 0, 32'h1357_9BDF, 32'h2468_ACE0, 5, 1'b1, 0);
            xfer(wr[0], 1, 2, 32'h0000_BEEF, 32'hF00D_CAFE, 5, 1'b1, 1);
            xfer(wr[0], 0, 3, 32'h0000_0077, 32'hAB00_0000, 5, 1'b1, 4);
            xfer(wr[0], 2, 1, 32'h89AB_CDEF, 32'h7654_3210, 5, 1'b1, 6);
            xfer(wr[0], 0, 1, 32'h0000_00E1, 32'h0000_5A00, 0, 1'b1, 9);
        end
        // R5: size code 3 behaves as word
        xfer(1'b0, 3, 2, 32'h0, 32'hDEAD_BEEF, 1, 1'b0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule